// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Host View

This block keeps time of day and date in packed BCD: hundredths of a second, seconds, minutes, hours, day of week, date, month and year. It advances once for each single-cycle `tick` strobe, which the surrounding logic supplies at 100 Hz. A companion oscillator and any supply or backup handling live outside the block.

The block holds two copies of the time. The working copy advances on every running tick. The host copy is what the byte-wide register port returns. The host copy takes the working value on each running tick unless the transfer-enable bit is cleared. With the bit cleared, software can read a stable snapshot of all eight fields while the working copy keeps counting, so no time is lost. A stop bit in the month register halts counting. A mode bit in the hours register selects 12-hour display with an afternoon flag.

Register map (byte addresses): 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year, 8 control. A write takes one clock. Reads are combinational from `addr`.

Top module: `bcdCalendarClock`

## Requirements
- R1: After reset all fields read 0x00, except day of week, date and month, which read 0x01. Control bit 0 (transfer enable) reads 1, and hours bit 6 reads 0, which selects 24-hour mode.
- R2: When month bit 7 is 0, each `tick` advances hundredths 00..99 in BCD. While transfer enable is 1, the host copy equals the working copy on the cycle after each tick.
- R3: The carries all happen on the tick where hundredths go from 99 to 00. Seconds and minutes roll 59 to 00. In 24-hour mode hours roll 23 to 00, and that rollover advances the date.
- R4: When hours bit 6 is 1 the hours are 12-hour, bit 5 is the PM flag and bits 4:0 hold 01..12. The step 11 to 12 toggles bit 5, and 12 is followed by 01. Only the step from 11 PM to 12 AM advances the date.
- R5: Day of week counts 1..7 and wraps to 1. The date wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends at 29 when the BCD year is divisible by 4, else at 28.
- R6: After December 31 the month becomes 01, and the year advances, with 99 followed by 00.
- R7: While control bit 0 is 0, the host copy holds its value across ticks and the working copy keeps counting. After bit 0 is set again, the next tick loads the host copy from the working copy.
- R8: A write to addresses 0..7 with transfer enable 1 loads both copies. With transfer enable 0 it loads only the host copy, and the next transfer overwrites that value.
- R9: While month bit 7 (active-high stop) is 1, ticks change neither copy. Counting resumes once the bit is cleared.
- R10: Unused bits read 0 whatever was written: seconds and minutes bit 7, hours bit 7, day of week bits 7:3, date bits 7:6, month bits 6:5, and control bits 7:1. Addresses 9..15 read 0x00.
- R11: When a write and a tick fall in the same cycle, the written field takes the written value. Every other field advances as for the tick alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per hundredth of a second |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |

## Verification
The bound checker watches relations that must hold on every cycle:
- the host copy stays still while frozen;
- the host copy matches the working copy after an unfrozen tick;
- both copies stay still while the stop bit is set;
- hundredths move on every running tick;
- unused bits are zero at the read port.

The calendar behaviour can only be shown by the bench's scenarios, which drive chosen dates up to a rollover and compare against a decimal reference model. Those scenarios cover month lengths, leap February, year wrap, the 12-hour PM sequence and write/tick collisions.

// File: rtl/bcdClockPkg.sv
package bcdClockPkg;
  localparam int FIELDS    = 8;
  localparam int ADDR_W    = 4;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = $clog2(FIELDS);
  localparam int CTRL_ADDR = FIELDS;
  localparam int F_HUN  = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HOUR = 3;
  localparam int F_DAY  = 4;
  localparam int F_DATE = 5;
  localparam int F_MON  = 6;
  localparam int F_YEAR = 7;

  typedef struct packed {
    logic              tickRun;
    logic              xfer;
    logic [FIELDS-1:0] wrSel;
    logic              wrInt;
    logic [BYTE_W-1:0] wrByte;
  } clkStrobe_t;

  function automatic logic [BYTE_W-1:0] fieldMask(input int idx);
    case (idx)
      F_SEC, F_MIN, F_HOUR: fieldMask = 8'h7F;
      F_DAY:                fieldMask = 8'h07;
      F_DATE:               fieldMask = 8'h3F;
      F_MON:                fieldMask = 8'h9F;
      default:              fieldMask = 8'hFF;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] resetValue(input int idx);
    case (idx)
      F_DAY, F_DATE, F_MON: resetValue = 8'h01;
      default:              resetValue = 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] bcdInc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeapBcd(input logic [BYTE_W-1:0] yr);
    if (yr[4]) isLeapBcd = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       isLeapBcd = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [BYTE_W-1:0] monthLen(input logic [4:0] mon, input logic [BYTE_W-1:0] yr);
    case (mon)
      5'h02:                      monthLen = isLeapBcd(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: monthLen = 8'h30;
      default:                    monthLen = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcdClockCtrl.sv
module bcdClockCtrl
  import bcdClockPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              oscStop,
  input  logic [BYTE_W-1:0] extR [FIELDS],
  output clkStrobe_t        st,
  output logic              teQ,
  output logic [BYTE_W-1:0] rdData
);
  always_ff @(posedge clk) begin
    if (!rstN) teQ <= 1'b1;
    else if (wrEn && addr == ADDR_W'(CTRL_ADDR)) teQ <= wrData[0];
  end

  always_comb begin
    st.tickRun = tick && !oscStop;
    st.xfer    = st.tickRun && teQ;
    st.wrInt   = teQ;
    st.wrByte  = wrData;
    for (int i = 0; i < FIELDS; i++) st.wrSel[i] = wrEn && (addr == ADDR_W'(i));
  end

  always_comb begin
    if (addr < ADDR_W'(FIELDS))          rdData = extR[addr[IDX_W-1:0]];
    else if (addr == ADDR_W'(CTRL_ADDR)) rdData = {{(BYTE_W-1){1'b0}}, teQ};
    else                                 rdData = '0;
  end
endmodule

// File: rtl/bcdClockDatapath.sv
module bcdClockDatapath
  import bcdClockPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  clkStrobe_t        st,
  output logic              oscStop,
  output logic [BYTE_W-1:0] intR [FIELDS],
  output logic [BYTE_W-1:0] extR [FIELDS]
);
  logic [BYTE_W-1:0] advR [FIELDS];
  logic [BYTE_W-1:0] hrTmp, monTmp;
  logic hunWrap, secWrap, minWrap, dayCarry, dateWrap, monWrap;

  assign oscStop = intR[F_MON][7];

  always_comb begin
    for (int i = 0; i < FIELDS; i++) advR[i] = intR[i];
    hunWrap  = intR[F_HUN] == 8'h99;
    secWrap  = hunWrap && intR[F_SEC] == 8'h59;
    minWrap  = secWrap && intR[F_MIN] == 8'h59;
    dayCarry = 1'b0;
    hrTmp    = '0;
    monTmp   = '0;
    advR[F_HUN] = hunWrap ? 8'h00 : bcdInc(intR[F_HUN]);
    if (hunWrap) advR[F_SEC] = secWrap ? 8'h00 : bcdInc(intR[F_SEC]);
    if (secWrap) advR[F_MIN] = minWrap ? 8'h00 : bcdInc(intR[F_MIN]);
    if (minWrap) begin
      if (intR[F_HOUR][6]) begin
        if (intR[F_HOUR][4:0] == 5'h11) begin
          advR[F_HOUR] = {2'b01, ~intR[F_HOUR][5], 5'h12};
          dayCarry     = intR[F_HOUR][5];
        end else if (intR[F_HOUR][4:0] == 5'h12) begin
          advR[F_HOUR] = {2'b01, intR[F_HOUR][5], 5'h01};
        end else begin
          hrTmp        = bcdInc({3'b000, intR[F_HOUR][4:0]});
          advR[F_HOUR] = {2'b01, intR[F_HOUR][5], 5'h00} | (hrTmp & 8'h1F);
        end
      end else if (intR[F_HOUR][5:0] == 6'h23) begin
        advR[F_HOUR] = 8'h00;
        dayCarry     = 1'b1;
      end else begin
        advR[F_HOUR] = bcdInc({2'b00, intR[F_HOUR][5:0]});
      end
    end
    dateWrap = dayCarry && intR[F_DATE] == monthLen(intR[F_MON][4:0], intR[F_YEAR]);
    monWrap  = dateWrap && intR[F_MON][4:0] == 5'h12;
    if (dayCarry) begin
      advR[F_DAY]  = (intR[F_DAY] == 8'h07) ? 8'h01 : bcdInc(intR[F_DAY]);
      advR[F_DATE] = dateWrap ? 8'h01 : bcdInc(intR[F_DATE]);
    end
    if (dateWrap) begin
      monTmp      = bcdInc({3'b000, intR[F_MON][4:0]});
      advR[F_MON] = {intR[F_MON][7], 7'h00} | (monWrap ? 8'h01 : (monTmp & 8'h1F));
    end
    if (monWrap) advR[F_YEAR] = (intR[F_YEAR] == 8'h99) ? 8'h00 : bcdInc(intR[F_YEAR]);
  end

  for (genvar g = 0; g < FIELDS; g++) begin : gField
    localparam logic [BYTE_W-1:0] MASK = fieldMask(g);
    localparam logic [BYTE_W-1:0] RVAL = resetValue(g);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        intR[g] <= RVAL;
        extR[g] <= RVAL;
      end else begin
        if (st.wrSel[g] && st.wrInt) intR[g] <= st.wrByte & MASK;
        else if (st.tickRun)         intR[g] <= advR[g];
        if (st.wrSel[g])             extR[g] <= st.wrByte & MASK;
        else if (st.xfer)            extR[g] <= advR[g];
      end
    end
  end
endmodule

// File: rtl/bcdCalendarClock.sv
module bcdCalendarClock
  import bcdClockPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData
);
  clkStrobe_t        st;
  logic              teQ;
  logic              oscStop;
  logic              tickRun;
  logic [BYTE_W-1:0] intR [FIELDS];
  logic [BYTE_W-1:0] extR [FIELDS];
  logic [FIELDS*BYTE_W-1:0] intFlat, extFlat;

  bcdClockCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .oscStop(oscStop), .extR(extR), .st(st), .teQ(teQ), .rdData(rdData)
  );

  bcdClockDatapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .oscStop(oscStop), .intR(intR), .extR(extR)
  );

  assign tickRun = st.tickRun;
  for (genvar g = 0; g < FIELDS; g++) begin : gFlat
    assign intFlat[g*BYTE_W +: BYTE_W] = intR[g];
    assign extFlat[g*BYTE_W +: BYTE_W] = extR[g];
  end
endmodule

// File: rtl/bcdClockChecker.sv
module bcdClockChecker
  import bcdClockPkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [ADDR_W-1:0]        addr,
  input logic [BYTE_W-1:0]        rdData,
  input logic                     teQ,
  input logic                     tickRun,
  input logic [FIELDS*BYTE_W-1:0] intFlat,
  input logic [FIELDS*BYTE_W-1:0] extFlat
);
  // R7: frozen host copy does not move
  a_r7_host_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!teQ && !wrEn) |=> $stable(extFlat));
  // R2: unfrozen tick makes the host copy equal the working copy
  a_r2_transfer_match: assert property (@(posedge clk) disable iff (!rstN)
    (tickRun && teQ && !wrEn) |=> (extFlat == intFlat));
  // R2: hundredths change on every running tick
  a_r2_hundredths_move: assert property (@(posedge clk) disable iff (!rstN)
    (tickRun && !wrEn) |=> (intFlat[7:0] != $past(intFlat[7:0])));
  // R9: stop bit holds the working copy
  a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (intFlat[F_MON*BYTE_W+7] && !wrEn) |=> $stable(intFlat));
  // R10: unused bits read zero
  a_r10_hours_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(F_HOUR)) |-> (rdData[7] == 1'b0));
  a_r10_day_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(F_DAY)) |-> (rdData[7:3] == 5'd0));
  a_r10_ctrl_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(CTRL_ADDR)) |-> (rdData[7:1] == 7'd0));
endmodule

bind bcdCalendarClock bcdClockChecker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .rdData(rdData),
  .teQ(teQ), .tickRun(tickRun), .intFlat(intFlat), .extFlat(extFlat)
);

// File: tb/bcdCalendarClock_tb.sv
module bcdCalendarClock_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int nTests = 0;
  int nFails = 0;
  int cycles = 0;
  string curReq = "R1";
  logic [63:0] mInt, mExt;
  logic mTe;
  int rot = 0;

  bcdCalendarClock u_dut (.clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
                          .addr(addr), .wrData(wrData), .rdData(rdData));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  function automatic int b2d(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] d2b(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic logic [7:0] mMask(input int i);
    case (i)
      1, 2, 3: return 8'h7F;
      4:       return 8'h07;
      5:       return 8'h3F;
      6:       return 8'h9F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [63:0] mAdv(input logic [63:0] s);
    int h, sc, mn, v, dy, dt, mo, yr, dim;
    logic pm, hr12, dayRoll;
    logic [7:0] t;
    dayRoll = 1'b0;
    h = b2d(s[7:0]) + 1;
    if (h == 100) begin
      h = 0;
      sc = b2d(s[15:8]) + 1;
      if (sc == 60) begin
        sc = 0;
        mn = b2d(s[23:16]) + 1;
        if (mn == 60) begin
          mn = 0;
          hr12 = s[30];
          pm = s[29];
          if (hr12) begin
            v = b2d({3'b000, s[28:24]});
            if (v == 11) begin v = 12; dayRoll = pm; pm = !pm; end
            else if (v == 12) v = 1;
            else v = v + 1;
            t = d2b(v);
            s[31:24] = {2'b01, pm, t[4:0]};
          end else begin
            v = b2d({2'b00, s[29:24]}) + 1;
            if (v == 24) begin v = 0; dayRoll = 1'b1; end
            s[31:24] = d2b(v);
          end
        end
        s[23:16] = d2b(mn);
      end
      s[15:8] = d2b(sc);
    end
    s[7:0] = d2b(h);
    if (dayRoll) begin
      dy = b2d(s[39:32]);
      dy = (dy == 7) ? 1 : dy + 1;
      s[39:32] = d2b(dy);
      dt = b2d(s[47:40]);
      mo = b2d({3'b000, s[52:48]});
      yr = b2d(s[63:56]);
      if (mo == 2) dim = (yr % 4 == 0) ? 29 : 28;
      else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
      else dim = 31;
      if (dt == dim) begin
        dt = 1;
        if (mo == 12) begin mo = 1; yr = (yr + 1) % 100; end
        else mo = mo + 1;
      end else dt = dt + 1;
      s[47:40] = d2b(dt);
      t = d2b(mo);
      s[55:48] = {s[55], 2'b00, t[4:0]};
      s[63:56] = d2b(yr);
    end
    return s;
  endfunction

  function automatic logic [7:0] mRead(input int a);
    if (a < 8) return mExt[a*8 +: 8];
    if (a == 8) return {7'd0, mTe};
    return 8'h00;
  endfunction

  task automatic mUpdate(input logic t, input logic w, input int a, input logic [7:0] d);
    logic [63:0] adv;
    logic oldTe;
    oldTe = mTe;
    adv = mInt;
    if (t && !mInt[55]) begin
      adv = mAdv(mInt);
      if (oldTe) mExt = adv;
    end
    if (w && a < 8) begin
      mExt[a*8 +: 8] = d & mMask(a);
      if (oldTe) adv[a*8 +: 8] = d & mMask(a);
    end
    if (w && a == 8) mTe = d[0];
    mInt = adv;
  endtask

  task automatic step(input logic t, input logic w, input int a, input logic [7:0] d);
    tick = t; wrEn = w; addr = 4'(a); wrData = d;
    @(posedge clk);
    @(negedge clk);
    mUpdate(t, w, a, d);
    nTests++;
    if (rdData !== mRead(a)) begin
      nFails++;
      $display("FAIL %s model compare addr %0d: actual %h expected %h", curReq, a, rdData, mRead(a));
    end
    tick = 0; wrEn = 0;
  endtask

  task automatic idle();
    step(0, 0, rot, 8'h00);
    rot = (rot + 1) % 9;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    step(0, 1, a, d);
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1, 0, rot, 8'h00);
      rot = (rot + 1) % 9;
      idle();
    end
  endtask

  task automatic checkVal(input int a, input logic [7:0] exp, input string req);
    step(0, 0, a, 8'h00);
    nTests++;
    if (rdData !== exp) begin
      nFails++;
      $display("FAIL %s addr %0d: actual %h expected %h", req, a, rdData, exp);
    end
  endtask

  task automatic setTime(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                         input logic [7:0] dy, input logic [7:0] hr);
    wr(7, yr); wr(6, mo); wr(5, dt); wr(4, dy); wr(3, hr);
    wr(2, 8'h59); wr(1, 8'h59); wr(0, 8'h98);
  endtask

  initial begin
    mInt = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
    mExt = mInt;
    mTe = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    curReq = "R1";
    checkVal(0, 8'h00, "R1"); checkVal(1, 8'h00, "R1"); checkVal(3, 8'h00, "R1");
    checkVal(4, 8'h01, "R1"); checkVal(5, 8'h01, "R1"); checkVal(6, 8'h01, "R1");
    checkVal(7, 8'h00, "R1"); checkVal(8, 8'h01, "R1");

    curReq = "R2";
    runTicks(250);
    checkVal(0, 8'h50, "R2"); checkVal(1, 8'h02, "R2");

    curReq = "R3";
    setTime(8'h23, 8'h02, 8'h28, 8'h07, 8'h23);
    runTicks(2);
    checkVal(0, 8'h00, "R3"); checkVal(1, 8'h00, "R3"); checkVal(2, 8'h00, "R3");
    checkVal(3, 8'h00, "R3"); checkVal(4, 8'h01, "R5");
    checkVal(5, 8'h01, "R5"); checkVal(6, 8'h03, "R5"); checkVal(7, 8'h23, "R5");

    curReq = "R5";
    setTime(8'h24, 8'h02, 8'h28, 8'h02, 8'h23);
    runTicks(2);
    checkVal(5, 8'h29, "R5"); checkVal(6, 8'h02, "R5");
    setTime(8'h24, 8'h02, 8'h29, 8'h03, 8'h23);
    runTicks(2);
    checkVal(5, 8'h01, "R5"); checkVal(6, 8'h03, "R5");
    setTime(8'h25, 8'h04, 8'h30, 8'h04, 8'h23);
    runTicks(2);
    checkVal(5, 8'h01, "R5"); checkVal(6, 8'h05, "R5");

    curReq = "R6";
    setTime(8'h99, 8'h12, 8'h31, 8'h05, 8'h23);
    runTicks(2);
    checkVal(5, 8'h01, "R6"); checkVal(6, 8'h01, "R6"); checkVal(7, 8'h00, "R6");

    curReq = "R4";
    setTime(8'h10, 8'h06, 8'h10, 8'h03, 8'h51);
    runTicks(2);
    checkVal(3, 8'h72, "R4"); checkVal(5, 8'h10, "R4");
    setTime(8'h10, 8'h06, 8'h10, 8'h03, 8'h72);
    runTicks(2);
    checkVal(3, 8'h61, "R4");
    setTime(8'h10, 8'h06, 8'h10, 8'h03, 8'h71);
    runTicks(2);
    checkVal(3, 8'h52, "R4"); checkVal(4, 8'h04, "R4"); checkVal(5, 8'h11, "R4");

    curReq = "R7";
    wr(0, 8'h10);
    wr(8, 8'h00);
    runTicks(5);
    checkVal(0, 8'h10, "R7");
    wr(1, 8'h33);
    checkVal(1, 8'h33, "R8");
    wr(8, 8'h01);
    checkVal(0, 8'h10, "R7");
    runTicks(1);
    checkVal(0, 8'h16, "R7"); checkVal(1, 8'h00, "R8");

    curReq = "R9";
    wr(0, 8'h42);
    wr(6, 8'hFF);
    checkVal(6, 8'h9F, "R10");
    runTicks(3);
    checkVal(0, 8'h42, "R9");
    curReq = "R10";
    wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF); wr(8, 8'hFF);
    checkVal(1, 8'h7F, "R10"); checkVal(2, 8'h7F, "R10"); checkVal(3, 8'h7F, "R10");
    checkVal(4, 8'h07, "R10"); checkVal(5, 8'h3F, "R10"); checkVal(8, 8'h01, "R10");
    for (int a = 9; a < 16; a++) checkVal(a, 8'h00, "R10");
    wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h12); wr(4, 8'h01); wr(5, 8'h15);
    wr(6, 8'h06);
    curReq = "R9";
    runTicks(1);
    checkVal(0, 8'h43, "R9");

    curReq = "R11";
    wr(0, 8'h99);
    step(1, 1, 1, 8'h20);
    checkVal(0, 8'h00, "R11"); checkVal(1, 8'h20, "R11");

    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r, a;
      r = $urandom_range(0, 9);
      a = $urandom_range(0, 2);
      if (r < 2) step($urandom_range(0, 1) == 1, 1, a, d2b($urandom_range(0, a == 0 ? 99 : 59)));
      else if (r == 2) step($urandom_range(0, 1) == 1, 1, 8, 8'($urandom_range(0, 1)));
      else if (r < 7) step(1, 0, $urandom_range(0, 8), 8'h00);
      else idle();
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule